// File: doc/BRIEF.md
# Overclock Recovery Watchdog

This block supervises a clock generator that may have been programmed to an unstable, overclocked frequency. Software arms it through a small register port. While it is armed, a down counter measures an interval in units of a periodic tick, where one tick stands for 290 ms. If software does not service it before the interval runs out, the block latches an alarm. It then raises a force flag so that the frequency selection falls back to a stored 5-bit safe code.

Software writes two bytes. The count byte sets the length of the interval. The control byte holds the enable, a status-clear bit and the safe frequency code. A service strobe restarts the interval. The tick that marks each 290 ms unit comes from outside this block, and so does the logic that actually switches the frequency. The register port is a plain write strobe with no back-pressure, so every write takes effect on the clock edge where it is presented. All pins are plain control and status signals.

Top module: `oc_recovery_wdog`

## Requirements
- R1: After reset the count byte is 16 (about 4.6 s), the watchdog is disabled, and `alarm_o`, `force_o` and `safe_code_o` are all 0.
- R2: A write with `reg_sel_i` = 1 loads the control byte, where bit 6 is enable (1 = on), bit 5 is the alarm-clear bit and bits 4:0 are the safe code. `safe_code_o` shows bits 4:0 from the edge of the write. Bit 7 has no effect.
- R3: Once enabled with a count N of at least 1, `alarm_o` stays 0 through N-1 ticks and becomes 1 on the edge of the Nth tick after the last reload.
- R4: A count of 0 raises the alarm on the first tick after the reload.
- R5: A `service_i` pulse reloads the counter from the count byte, so the full N ticks are needed again before the alarm.
- R6: A write with `reg_sel_i` = 0 stores the count byte and reloads the counter with the new value at once.
- R7: The alarm latches. Further ticks and service pulses do not clear it, and `force_o` equals `alarm_o` at all times.
- R8: A control write with bit 6 = 1 and bit 5 = 1 clears the alarm and restarts the interval. A control write with bit 6 = 0 clears the alarm and stops the watchdog.
- R9: While the watchdog is disabled, ticks are ignored and the alarm never rises.
- R10: If a reload (service or count write) arrives in the same cycle as the tick that would expire the interval, the reload wins: there is no alarm and a fresh interval of N ticks starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 = count byte, 1 = control byte |
| reg_wdata_i | input | 8 | Register write data |
| tick_i | input | 1 | One-cycle pulse marking each 290 ms unit |
| service_i | input | 1 | Service pulse that restarts the interval |
| alarm_o | output | 1 | Latched alarm status |
| force_o | output | 1 | Request to force the safe frequency code |
| safe_code_o | output | 5 | Stored safe frequency code |

## Verification
The service strobe and the tick that would end the interval can land in the same clock cycle, and so can a count write and such a tick. The bench arms a count of 2 and sends one tick. It then presents the second tick in the same cycle as a service pulse, and in another run in the same cycle as a count write. It judges the result by checking that no alarm appears, that one more tick still leaves the alarm low, and that the alarm rises exactly on the tick after that.

// File: rtl/ocwd_pkg.sv
package ocwd_pkg;
  localparam int BYTE_W = 8;
  typedef enum logic {
    SEL_COUNT = 1'b0,
    SEL_CTRL  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/ocwd_regs.sv
module ocwd_regs
  import ocwd_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int CODE_W  = 5,
  parameter int CNT_RST = 16,
  parameter int EN_BIT  = 6,
  parameter int CLR_BIT = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              sel_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  count_q,
  output logic              en_q,
  output logic [CODE_W-1:0] code_q,
  output logic              cnt_wr_o,
  output logic              restart_o,
  output logic              clr_o
);
  logic ctrl_wr;

  assign cnt_wr_o  = wr_i && (sel_i == SEL_COUNT);
  assign ctrl_wr   = wr_i && (sel_i == SEL_CTRL);
  assign restart_o = ctrl_wr && wdata_i[EN_BIT];
  assign clr_o     = ctrl_wr && (!wdata_i[EN_BIT] || wdata_i[CLR_BIT]);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      count_q <= CNT_W'(CNT_RST);
      en_q    <= 1'b0;
      code_q  <= '0;
    end else begin
      if (cnt_wr_o) count_q <= wdata_i[CNT_W-1:0];
      if (ctrl_wr) begin
        en_q   <= wdata_i[EN_BIT];
        code_q <= wdata_i[CODE_W-1:0];
      end
    end
  end

  // R6
  count_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_wr_o |=> $stable(count_q));
  // R2
  code_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_wr |=> ($stable(code_q) && $stable(en_q)));
endmodule

// File: rtl/ocwd_interval.sv
module ocwd_interval #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] rst_val_i,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic [CNT_W-1:0] remain_q;
  logic             last_unit;

  assign last_unit = (remain_q <= ONE);
  assign expire_o  = run_i && tick_i && !reload_i && last_unit;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)                            remain_q <= rst_val_i;
    else if (reload_i)                      remain_q <= load_val_i;
    else if (run_i && tick_i && !last_unit) remain_q <= remain_q - ONE;
  end

  // R3
  no_climb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reload_i |=> (remain_q <= $past(remain_q)));
  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !reload_i) |=> $stable(remain_q));
  // R10
  reload_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |-> !expire_o);
endmodule

// File: rtl/ocwd_alarm.sv
module ocwd_alarm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic clr_i,
  output logic alarm_q
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni)       alarm_q <= 1'b0;
    else if (clr_i)    alarm_q <= 1'b0;
    else if (expire_i) alarm_q <= 1'b1;
  end

  // R7
  alarm_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_q && !clr_i) |=> alarm_q);
  // R3
  alarm_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && !clr_i) |=> alarm_q);
  // R8
  alarm_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !alarm_q);
endmodule

// File: rtl/oc_recovery_wdog.sv
module oc_recovery_wdog
  import ocwd_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int CODE_W  = 5,
  parameter int CNT_RST = 16,
  parameter int EN_BIT  = 6,
  parameter int CLR_BIT = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_sel_i,
  input  logic [7:0]        reg_wdata_i,
  input  logic              tick_i,
  input  logic              service_i,
  output logic              alarm_o,
  output logic              force_o,
  output logic [CODE_W-1:0] safe_code_o
);
  logic [CNT_W-1:0] count_q, load_val;
  logic en_q, cnt_wr, restart, clr, reload, run, expire, alarm_q;

  ocwd_regs #(
    .CNT_W(CNT_W), .CODE_W(CODE_W), .CNT_RST(CNT_RST),
    .EN_BIT(EN_BIT), .CLR_BIT(CLR_BIT)
  ) regs_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(reg_wr_i), .sel_i(reg_sel_i),
    .wdata_i(reg_wdata_i), .count_q(count_q), .en_q(en_q),
    .code_q(safe_code_o), .cnt_wr_o(cnt_wr), .restart_o(restart), .clr_o(clr)
  );

  assign reload   = service_i || cnt_wr || restart;
  assign load_val = cnt_wr ? reg_wdata_i[CNT_W-1:0] : count_q;
  assign run      = en_q && !alarm_q;

  ocwd_interval #(.CNT_W(CNT_W)) interval_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .reload_i(reload),
    .load_val_i(load_val), .tick_i(tick_i), .rst_val_i(CNT_W'(CNT_RST)),
    .expire_o(expire)
  );

  ocwd_alarm alarm_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .expire_i(expire), .clr_i(clr),
    .alarm_q(alarm_q)
  );

  assign alarm_o = alarm_q;
  assign force_o = alarm_q;

  // R9
  off_no_alarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> !alarm_q);
  // R7
  alarm_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_q && !reg_wr_i) |=> alarm_q);
endmodule

// File: tb/oc_recovery_wdog_tb_top.sv
module oc_recovery_wdog_tb_top;
  logic clk = 1'b0;
  logic rst_n, wr, sel, tick, svc;
  logic [7:0] wdata;
  logic alarm, force_f;
  logic [4:0] code;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  oc_recovery_wdog dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_sel_i(sel),
    .reg_wdata_i(wdata), .tick_i(tick), .service_i(svc),
    .alarm_o(alarm), .force_o(force_f), .safe_code_o(code)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_alarm(string req, logic exp);
    chk(req, {7'd0, alarm}, {7'd0, exp});
    chk({req, " force"}, {7'd0, force_f}, {7'd0, exp});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr = 1'b0; sel = 1'b0; tick = 1'b0; svc = 1'b0; wdata = '0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_reg(logic s, logic [7:0] d);
    wr = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk_alarm("R1 alarm after reset", 1'b0);
    chk("R1 code after reset", {3'd0, code}, 8'd0);
    ticks(20);
    chk_alarm("R1 disabled after reset", 1'b0);
    wr_reg(1'b1, 8'h40);
    ticks(15);
    chk_alarm("R1 default count 16 minus one", 1'b0);
    ticks(1);
    chk_alarm("R1 default count 16", 1'b1);
  endtask

  task automatic t_regs();
    do_reset();
    wr_reg(1'b1, 8'h95);
    chk("R2 safe code bits 4:0", {3'd0, code}, 8'h15);
    ticks(3);
    chk_alarm("R2 bit7 without enable stays off", 1'b0);
    wr_reg(1'b1, 8'h4A);
    chk("R2 safe code rewrite", {3'd0, code}, 8'h0A);
  endtask

  task automatic t_count();
    do_reset();
    wr_reg(1'b0, 8'd5);
    wr_reg(1'b1, 8'h43);
    ticks(4);
    chk_alarm("R3 count 5 after 4 ticks", 1'b0);
    ticks(1);
    chk_alarm("R3 count 5 after 5 ticks", 1'b1);
    chk("R3 safe code on alarm", {3'd0, code}, 8'h03);
  endtask

  task automatic t_zero();
    do_reset();
    wr_reg(1'b0, 8'd0);
    wr_reg(1'b1, 8'h40);
    chk_alarm("R4 zero count before tick", 1'b0);
    ticks(1);
    chk_alarm("R4 zero count first tick", 1'b1);
  endtask

  task automatic t_service();
    do_reset();
    wr_reg(1'b0, 8'd4);
    wr_reg(1'b1, 8'h40);
    ticks(3);
    svc = 1'b1; @(negedge clk); svc = 1'b0;
    ticks(3);
    chk_alarm("R5 service restarts interval", 1'b0);
    ticks(1);
    chk_alarm("R5 expiry after service", 1'b1);
  endtask

  task automatic t_countwrite();
    do_reset();
    wr_reg(1'b0, 8'd3);
    wr_reg(1'b1, 8'h40);
    ticks(2);
    wr_reg(1'b0, 8'd6);
    ticks(5);
    chk_alarm("R6 new count reloaded", 1'b0);
    ticks(1);
    chk_alarm("R6 new count expiry", 1'b1);
  endtask

  task automatic t_latch();
    do_reset();
    wr_reg(1'b0, 8'd1);
    wr_reg(1'b1, 8'h40);
    ticks(1);
    ticks(5);
    svc = 1'b1; @(negedge clk); svc = 1'b0;
    chk_alarm("R7 alarm held through ticks and service", 1'b1);
  endtask

  task automatic t_clear();
    do_reset();
    wr_reg(1'b0, 8'd2);
    wr_reg(1'b1, 8'h40);
    ticks(2);
    chk_alarm("R8 alarm before clear", 1'b1);
    wr_reg(1'b1, 8'h60);
    chk_alarm("R8 status clear", 1'b0);
    ticks(1);
    chk_alarm("R8 restart one tick", 1'b0);
    ticks(1);
    chk_alarm("R8 restart expiry", 1'b1);
    wr_reg(1'b1, 8'h00);
    chk_alarm("R8 disable clears", 1'b0);
    ticks(4);
    chk_alarm("R9 disabled ignores ticks", 1'b0);
  endtask

  task automatic t_collide();
    do_reset();
    wr_reg(1'b0, 8'd2);
    wr_reg(1'b1, 8'h40);
    ticks(1);
    tick = 1'b1; svc = 1'b1; @(negedge clk); tick = 1'b0; svc = 1'b0;
    chk_alarm("R10 service beats tick", 1'b0);
    ticks(1);
    chk_alarm("R10 fresh interval one tick", 1'b0);
    ticks(1);
    chk_alarm("R10 fresh interval expiry", 1'b1);
    do_reset();
    wr_reg(1'b0, 8'd2);
    wr_reg(1'b1, 8'h40);
    ticks(1);
    tick = 1'b1; wr = 1'b1; sel = 1'b0; wdata = 8'd2;
    @(negedge clk);
    tick = 1'b0; wr = 1'b0; wdata = '0;
    ticks(1);
    chk_alarm("R10 count write beats tick", 1'b0);
    ticks(1);
    chk_alarm("R10 count write expiry", 1'b1);
  endtask

  initial begin
    t_reset();
    t_regs();
    t_count();
    t_zero();
    t_service();
    t_countwrite();
    t_latch();
    t_clear();
    t_collide();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule